// File: doc/BRIEF.md
# Frame slip buffer

This block is an elastic store that sits between a PCM link timed by the far end and the local exchange timing. Octets arrive on a write strobe driven by the recovered line timing. They leave on a read strobe driven by the local frame timing. Both strobes are enables in one clock domain.

The store has two frame slots, each of `FRAME_LEN` octets. After reset the write position leads the read position by one frame, which is half the store. This gives equal margin against drift in either direction.

A steady frequency offset between the two timings slowly moves the number of unread octets away from that centre. The controller corrects this only when the read side is about to start a new frame. It never slips single octets, so frame alignment is kept:
- If too few octets are buffered, it replays the frame just read (duplicate slip).
- If too many are buffered, it discards the oldest unread frame (delete slip).

Each slip raises a one-cycle pulse and bumps a saturating counter.

The read-side controller is a small state machine that tracks what kind of frame is being delivered:
- `RF_STEADY`: a normal frame.
- `RF_REPLAY`: a repeated frame.
- `RF_SKIPPED`: the frame that follows a deletion.

The state changes only on a read at frame offset 0. Each transition is named after the decision taken at that boundary:
- Any state moves to `RF_REPLAY` on a duplicate slip.
- Any state moves to `RF_SKIPPED` on a delete slip.
- Any state moves to `RF_STEADY` on a boundary with no slip.

Top module: `frame_slip_buffer`

## Requirements
- R1: While `rst_n` is low and just after release, `rd_octet` is 0, both counters are 0, both slip pulses are 0 and `rd_replay` is 0. Writing starts at store slot `FRAME_LEN` and reading at slot 0, so the first `FRAME_LEN` reads after reset return 0 unless those slots have been written.
- R2: `rd_octet` updates on the clock edge at which `rd_stb` is sampled high and holds otherwise. Without a slip, octets are delivered in the order they were written.
- R3: A slip decision is taken only on a read whose read position is at offset 0 of a frame. No slip ever happens on any other read, whatever the fill.
- R4: If, at such a boundary read, fewer than `FRAME_LEN/2` octets are unread, the read position moves back one frame. The octets of the frame just delivered are repeated, starting with its first octet.
- R5: If, at such a boundary read, more than `3*FRAME_LEN/2` octets are unread, the read position moves forward one frame, and the oldest unread frame is never delivered.
- R6: A fill of exactly `FRAME_LEN/2` or exactly `3*FRAME_LEN/2` at a boundary read causes no slip.
- R7: `slip_dup` or `slip_del` is high for exactly the cycle in which the first octet of the repeated frame, or of the frame after the deleted one, appears on `rd_octet`. The two are never high together.
- R8: `dup_count` and `del_count` increase by one on the same edge as their pulse. Each saturates at `2**CNT_W-1`.
- R9: `rd_replay` is high from the first octet of a repeated frame until the next boundary read, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Octet valid from the line side |
| wr_octet | input | OCTET_W | Octet from the line side |
| rd_stb | input | 1 | Local timing requests the next octet |
| rd_octet | output | OCTET_W | Octet delivered, registered |
| rd_replay | output | 1 | The frame being delivered is a repeat |
| slip_dup | output | 1 | One-cycle pulse on a duplicate slip |
| slip_del | output | 1 | One-cycle pulse on a delete slip |
| dup_count | output | CNT_W | Saturating count of duplicate slips |
| del_count | output | CNT_W | Saturating count of delete slips |

## Verification
The hardest situation to reach is a boundary read with the fill exactly on a threshold, or just one octet past it, because the fill drifts only through the ratio of the two strobes. Directed steps start from reset and issue write-only, read-only and joint cycles in exact counts. This places the fill at 48, then 16, then 15 and 49 at successive read boundaries. The 15 also sits mid-frame for a whole frame, to show that no slip is taken off the boundary. Long rate-offset runs then drive each counter into saturation. A reference model of the fill rule follows every cycle.

// File: rtl/slip_pkg.sv
package slip_pkg;

    // Kind of frame currently being delivered on the read side
    typedef enum logic [1:0] {
        RF_STEADY  = 2'd0,
        RF_REPLAY  = 2'd1,
        RF_SKIPPED = 2'd2
    } rd_frame_e;

    // Decision taken at a read-side frame boundary
    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_DUP  = 2'd1,
        SLIP_DEL  = 2'd2
    } slip_e;

endpackage

// File: rtl/slip_store.sv
module slip_store #(
    parameter int OCTET_W = 8,
    parameter int DEPTH   = 64,
    parameter int AW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [OCTET_W-1:0] wr_data,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [OCTET_W-1:0] rd_data
);

    logic [OCTET_W-1:0] mem [DEPTH];

    // Registered read returns the value held before a same-edge write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
            end
            if (rd_en) begin
                rd_data <= mem[rd_addr];
            end
        end
    end

endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl
    import slip_pkg::*;
#(
    parameter int FRAME_LEN = 32,
    parameter int AW        = 6,
    parameter int FILL_W    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          dup_evt,
    output logic          del_evt,
    output logic          slip_dup,
    output logic          slip_del,
    output logic          rd_replay
);

    localparam int FAW   = AW - 1;
    localparam int DEPTH = 2 * FRAME_LEN;
    localparam int LOW   = FRAME_LEN / 2;
    localparam int HIGH  = FRAME_LEN + FRAME_LEN / 2;
    localparam logic [AW-1:0]     FLIP   = AW'(FRAME_LEN);
    localparam logic [FILL_W-1:0] FRAMEF = FILL_W'(FRAME_LEN);

    logic [AW-1:0]     wptr, rptr, rptr_d;
    logic [FILL_W-1:0] fill, fill_adj, fill_d;
    logic              at_boundary;
    slip_e             slip_kind;
    rd_frame_e         state_q, state_d;

    // Boundary decision
    always_comb begin
        at_boundary = rd_stb && (rptr[FAW-1:0] == '0);
        slip_kind   = SLIP_NONE;
        if (at_boundary) begin
            if (fill < FILL_W'(LOW)) begin
                slip_kind = SLIP_DUP;
            end else if (fill > FILL_W'(HIGH)) begin
                slip_kind = SLIP_DEL;
            end
        end
    end

    // Address and fill arithmetic
    always_comb begin
        rd_addr = (slip_kind == SLIP_NONE) ? rptr : (rptr ^ FLIP);
        rptr_d  = rd_stb ? rd_addr + AW'(1) : rptr;
        unique case (slip_kind)
            SLIP_DUP: fill_adj = fill + FRAMEF;
            SLIP_DEL: fill_adj = fill - FRAMEF;
            default:  fill_adj = fill;
        endcase
        if (wr_stb && !rd_stb) begin
            fill_d = (fill_adj == FILL_W'(DEPTH)) ? fill_adj : fill_adj + FILL_W'(1);
        end else if (rd_stb && !wr_stb) begin
            fill_d = (fill_adj == '0) ? fill_adj : fill_adj - FILL_W'(1);
        end else begin
            fill_d = fill_adj;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= FLIP;
            rptr <= '0;
            fill <= FRAMEF;
        end else begin
            if (wr_stb) begin
                wptr <= wptr + AW'(1);
            end
            rptr <= rptr_d;
            fill <= fill_d;
        end
    end

    assign wr_addr = wptr;
    assign dup_evt = (slip_kind == SLIP_DUP);
    assign del_evt = (slip_kind == SLIP_DEL);

    // Next-state logic: transitions only at read boundaries
    always_comb begin
        state_d = state_q;
        if (at_boundary) begin
            unique case (slip_kind)
                SLIP_DUP: state_d = RF_REPLAY;
                SLIP_DEL: state_d = RF_SKIPPED;
                default:  state_d = RF_STEADY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_STEADY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: pulses line up with the first octet of the new frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slip_dup <= 1'b0;
            slip_del <= 1'b0;
        end else begin
            slip_dup <= dup_evt;
            slip_del <= del_evt;
        end
    end

    assign rd_replay = (state_q == RF_REPLAY);

    assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rptr[FAW-1:0] != '0) |=> (!slip_dup && !slip_del));

    assert_dup_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && fill < FILL_W'(LOW)) |=> (slip_dup && rptr[FAW-1:0] == FAW'(1)));

    assert_del_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && fill > FILL_W'(HIGH)) |=> (slip_del && rptr[FAW-1:0] == FAW'(1)));

    assert_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && (fill == FILL_W'(LOW) || fill == FILL_W'(HIGH))) |=> (!slip_dup && !slip_del));

    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slip_dup, slip_del}));

    assert_replay_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_replay) |-> slip_dup);

    assert_replay_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slip_del |-> (!rd_replay && state_q == RF_SKIPPED));

endmodule

// File: rtl/slip_counters.sv
module slip_counters #(
    parameter int CNT_W = 8,
    parameter int NUM   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic [CNT_W-1:0] q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (inc[g] && q != CNT_MAX) begin
                q <= q + CNT_W'(1);
            end
        end

        assign count[g] = q;

        assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (inc[g] && count[g] != CNT_MAX) |=> (count[g] == $past(count[g]) + CNT_W'(1)));

        assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (count[g] == CNT_MAX) |=> (count[g] == CNT_MAX));
    end

endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
    parameter int OCTET_W   = 8,
    parameter int FRAME_LEN = 32,
    parameter int CNT_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [OCTET_W-1:0] wr_octet,
    input  logic               rd_stb,
    output logic [OCTET_W-1:0] rd_octet,
    output logic               rd_replay,
    output logic               slip_dup,
    output logic               slip_del,
    output logic [CNT_W-1:0]   dup_count,
    output logic [CNT_W-1:0]   del_count
);

    localparam int DEPTH  = 2 * FRAME_LEN;
    localparam int AW     = $clog2(DEPTH);
    localparam int FILL_W = AW + 1;

    logic [AW-1:0]          wr_addr, rd_addr;
    logic                   dup_evt, del_evt;
    logic [1:0][CNT_W-1:0]  counts;

    slip_ctrl #(
        .FRAME_LEN(FRAME_LEN),
        .AW       (AW),
        .FILL_W   (FILL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .dup_evt  (dup_evt),
        .del_evt  (del_evt),
        .slip_dup (slip_dup),
        .slip_del (slip_del),
        .rd_replay(rd_replay)
    );

    slip_store #(
        .OCTET_W(OCTET_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_octet),
        .rd_en  (rd_stb),
        .rd_addr(rd_addr),
        .rd_data(rd_octet)
    );

    slip_counters #(
        .CNT_W(CNT_W),
        .NUM  (2)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  ({del_evt, dup_evt}),
        .count(counts)
    );

    assign dup_count = counts[0];
    assign del_count = counts[1];

endmodule

// File: tb/frame_slip_buffer_tb_top.sv
module frame_slip_buffer_tb_top;

    localparam int FL      = 32;
    localparam int DEP     = 2 * FL;
    localparam int CMAX    = 255;
    localparam int WD_CYC  = 150000;

    // Each row: write gap period, read gap period, cycles, expected (0 none, 1 dup only, 2 del only)
    localparam int SCN [6][4] = '{
        '{0, 0, 640,  0},
        '{0, 8, 1600, 2},
        '{8, 0, 1600, 1},
        '{0, 4, 1000, 2},
        '{5, 0, 1000, 1},
        '{3, 3, 640,  0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_stb, rd_stb;
    logic [7:0] wr_octet;
    logic [7:0] rd_octet;
    logic       rd_replay, slip_dup, slip_del;
    logic [7:0] dup_count, del_count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] m_mem [DEP];
    int         m_wp, m_rp, m_fill, m_dupc, m_delc;
    bit         m_replay, m_pdup, m_pdel;
    logic [7:0] m_rd;
    logic [7:0] wseq;
    int         n_dup, n_del;

    always #10 clk = ~clk;

    frame_slip_buffer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_octet (wr_octet),
        .rd_stb   (rd_stb),
        .rd_octet (rd_octet),
        .rd_replay(rd_replay),
        .slip_dup (slip_dup),
        .slip_del (slip_del),
        .dup_count(dup_count),
        .del_count(del_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEP; i++) m_mem[i] = '0;
        m_wp = FL; m_rp = 0; m_fill = FL;
        m_dupc = 0; m_delc = 0;
        m_replay = 0; m_pdup = 0; m_pdel = 0; m_rd = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cyc(input bit w, input bit r);
        int  kind, addr, adj;
        bit  bnd;
        @(negedge clk);
        wr_stb = w; rd_stb = r; wr_octet = wseq;
        bnd  = r && ((m_rp % FL) == 0);
        kind = 0;
        if (bnd) begin
            if (m_fill < FL / 2) kind = 1;
            else if (m_fill > FL + FL / 2) kind = 2;
        end
        m_pdup = (kind == 1);
        m_pdel = (kind == 2);
        if (m_pdup && m_dupc < CMAX) m_dupc++;
        if (m_pdel && m_delc < CMAX) m_delc++;
        if (bnd) m_replay = (kind == 1);
        if (r) begin
            addr = (kind != 0) ? (m_rp ^ FL) : m_rp;
            m_rd = m_mem[addr];
            m_rp = (addr + 1) % DEP;
        end
        adj = m_fill + ((kind == 1) ? FL : 0) - ((kind == 2) ? FL : 0);
        if (w && !r)      m_fill = (adj == DEP) ? adj : adj + 1;
        else if (r && !w) m_fill = (adj == 0) ? 0 : adj - 1;
        else              m_fill = adj;
        if (w) begin
            m_mem[m_wp] = wseq;
            m_wp = (m_wp + 1) % DEP;
            wseq = wseq + 8'd1;
        end
        @(posedge clk);
        #2;
        check(rd_octet == m_rd, "R2 rd_octet", rd_octet, m_rd);
        check(slip_dup == m_pdup && slip_del == m_pdel, "R7 pulses",
              {slip_dup, slip_del}, {m_pdup, m_pdel});
        check(dup_count == 8'(m_dupc), "R8 dup_count", dup_count, m_dupc);
        check(del_count == 8'(m_delc), "R8 del_count", del_count, m_delc);
        check(rd_replay == m_replay, "R9 rd_replay", rd_replay, m_replay);
        if (slip_dup) n_dup++;
        if (slip_del) n_del++;
    endtask

    initial begin
        #(WD_CYC * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R2): run did not complete, actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] first_prev;
        int d0;
        rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; wr_octet = '0;
        wseq = 8'd100; n_dup = 0; n_del = 0;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: values while in reset
        check(rd_octet == 0 && dup_count == 0 && del_count == 0, "R1 reset outputs", rd_octet, 0);
        check(!slip_dup && !slip_del && !rd_replay, "R1 reset flags",
              {slip_dup, slip_del, rd_replay}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: fill 48 at the first boundary, no delete (R6)
        repeat (16) cyc(1, 0);
        cyc(0, 1);
        check(slip_del == 0, "R6 fill at upper mark", slip_del, 0);
        check(rd_octet == 0, "R1 first read is lead slot", rd_octet, 0);
        // Fill 16 at the next boundary, no duplicate (R6)
        repeat (31) cyc(0, 1);
        cyc(0, 1);
        check(slip_dup == 0, "R6 fill at lower mark", slip_dup, 0);
        check(rd_octet == 8'd100, "R2 first written octet", rd_octet, 100);
        first_prev = rd_octet;
        // Fill 15 for a whole frame, no slip off the boundary (R3)
        d0 = n_dup;
        repeat (31) cyc(1, 1);
        check(n_dup == d0, "R3 no mid-frame slip", n_dup, d0);
        // Boundary with fill 15: duplicate (R4)
        cyc(0, 1);
        check(slip_dup == 1, "R4 duplicate pulse", slip_dup, 1);
        check(rd_octet == first_prev, "R4 replayed first octet", rd_octet, first_prev);
        check(rd_replay == 1, "R9 replay flag", rd_replay, 1);
        check(dup_count == 1, "R8 dup_count", dup_count, 1);
        repeat (31) cyc(1, 1);
        check(rd_replay == 1, "R9 replay held", rd_replay, 1);
        // Fill 49 at boundary: delete (R5)
        repeat (3) cyc(1, 0);
        cyc(0, 1);
        check(slip_del == 1, "R5 delete pulse", slip_del, 1);
        check(del_count == 1, "R8 del_count", del_count, 1);
        check(rd_replay == 0, "R9 replay cleared", rd_replay, 0);

        // Table of rate-offset scenarios
        for (int s = 0; s < 6; s++) begin
            do_reset();
            n_dup = 0; n_del = 0;
            for (int k = 0; k < SCN[s][2]; k++) begin
                cyc(!(SCN[s][0] != 0 && (k % SCN[s][0]) == 0),
                    !(SCN[s][1] != 0 && (k % SCN[s][1]) == 0));
            end
            if (SCN[s][3] == 0) begin
                check(n_dup == 0 && n_del == 0, "R4/R5 equal rates no slip", n_dup + n_del, 0);
            end else if (SCN[s][3] == 1) begin
                check(n_dup > 0 && n_del == 0, "R4 slow writer duplicates", n_dup, 1);
            end else begin
                check(n_del > 0 && n_dup == 0, "R5 fast writer deletes", n_del, 1);
            end
        end

        // Duplicate counter saturation (R8)
        do_reset();
        repeat (300 * FL + 64) cyc(0, 1);
        check(dup_count == 8'(CMAX), "R8 dup saturation", dup_count, CMAX);
        // Delete counter saturation (R8)
        do_reset();
        for (int k = 0; k < 40000; k++) cyc(1, (k % 4) != 0);
        check(del_count == 8'(CMAX), "R8 del saturation", del_count, CMAX);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule